// File: doc/BRIEF.md
# DMA Channel Command Mailbox and Interrupt Register Unit

This block is the software-facing control store of a multi-channel DMA engine. Software uses a simple word-addressed register port to do three things. It writes a command/status word for each channel, which holds a run state, an error code and a descriptor pointer. It posts per-channel commands (start, pause, flush) into a 2-bit-per-channel mailbox. It services a 2-bit-per-channel interrupt status. The channel datapath sits on the other side. It sees the commands that are pending and enabled, acknowledges them, and reports completion, pause and error events. The block folds those events into each channel's status word and interrupt field, and drives a single interrupt line.

To start a channel, software writes the descriptor pointer into the channel word with the start-pending code in the run-state bits, then posts a start command. Resuming from pause works the same way: the run-state bits are rewritten to start-pending and a start is posted again. An error event sets both interrupt bits of the channel and leaves it paused with an error code. Writing zero to a paused channel's word returns it to idle.

Top module: `dma_mbox_top`

## Requirements
- R1: After a synchronous active-high reset, all of these read zero: the mailbox, both mask registers, the interrupt status, the enable register and every channel word. In addition irq_o, cmd_pend and rdata are zero.
- R2: Register word addresses: 0 mailbox value, 1 mailbox set, 2 mailbox clear, 3 mailbox mask, 4 interrupt status, 5 interrupt set, 6 interrupt clear, 7 interrupt mask, 8 enable, 32+n channel n word. Set/clear addresses and unmapped addresses read as zero. Read data appears on rdata in the cycle after rd_en.
- R3: Channel n owns bits 2n+1:2n of the mailbox, and the codes are 01 start, 10 pause, 11 flush. A write to the set address ORs the written bits in, and a write to the clear address clears exactly the written bits. An acknowledge clears the channel's field when that field is presented. A set written in the same cycle as an acknowledge survives.
- R4: cmd_pend presents mailbox bits at the same positions, but only where the mailbox mask bit is 1 and the enable bit is 1. Otherwise the commands are held in the mailbox, and an acknowledge for a channel whose presented field is zero has no effect.
- R5: Bit 0 of the enable register reads back the value last written to it; the other bits read zero.
- R6: Channel events use the 2-bit code at evt_kind[2n+1:2n]. Code 0 (done) sets interrupt bit 2n and makes the run state idle. Code 1 (paused) sets bit 2n and makes the run state paused. Code 2 (error) sets bits 2n and 2n+1, makes the run state paused and stores evt_code[3n+2:3n] in the error field. Code 3 is ignored. The pointer is kept in every case.
- R7: A write to the interrupt set address ORs bits in, and a write to the clear address clears exactly the written bits. Status bits otherwise stay set, and an event in the same cycle as a clear survives it.
- R8: irq_o is high exactly when some interrupt status bit is set whose interrupt mask bit is 1. It changes on the same clock edge as the status.
- R9: A channel word holds the run state in bits 1:0 (00 idle, 01 running, 10 paused, 11 start-pending), an error code in bits 4:2 and the pointer above bit 4. A software write stores the whole word, so writing zero returns a paused channel to idle. An event on the same channel in the same cycle takes priority.
- R10: Acknowledging a presented start (01) sets the run state to running and keeps the pointer and error code. Acknowledging pause or flush leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, registered |
| cmd_pend | output | 2*NCH | Enabled, unmasked commands per channel |
| cmd_ack | input | NCH | Channel accepts its presented command |
| evt_valid | input | NCH | Channel event strobe |
| evt_kind | input | 2*NCH | Event code per channel |
| evt_code | input | 3*NCH | Error code per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same cycle. A software clear of the interrupt status can coincide with a channel event that sets a bit. A software post to the mailbox can coincide with a channel acknowledge that clears the same field. The bench drives each pair on one clock edge: a clear-all write alongside an error event, and a pause post alongside the acknowledge of a pending start. It then reads the registers back and expects the event bits and the new command to remain, with the acknowledged start reflected in the run state. Random traffic mixes all operations against a bench model, so other coincidences of masks, enable and acknowledges are covered too.

// File: rtl/dma_mbox_pkg.sv
package dma_mbox_pkg;
  typedef enum logic [1:0] {
    RS_IDLE    = 2'b00,
    RS_RUN     = 2'b01,
    RS_PAUSED  = 2'b10,
    RS_STARTPD = 2'b11
  } run_state_e;

  typedef enum logic [1:0] {
    EV_DONE   = 2'd0,
    EV_PAUSED = 2'd1,
    EV_ERROR  = 2'd2,
    EV_NONE   = 2'd3
  } evt_kind_e;

  localparam logic [1:0] CMD_START = 2'b01;
  localparam logic [1:0] CMD_PAUSE = 2'b10;
  localparam logic [1:0] CMD_FLUSH = 2'b11;

  localparam int A_MB_VAL    = 0;
  localparam int A_MB_SET    = 1;
  localparam int A_MB_CLR    = 2;
  localparam int A_MB_MASK   = 3;
  localparam int A_IRQ_STAT  = 4;
  localparam int A_IRQ_SET   = 5;
  localparam int A_IRQ_CLR   = 6;
  localparam int A_IRQ_MASK  = 7;
  localparam int A_ENABLE    = 8;
  localparam int A_CHAN_BASE = 32;

  localparam int ERR_LSB = 2;
  localparam int ERR_W   = 3;
endpackage

// File: rtl/dma_mbox_cmd.sv
module dma_mbox_cmd #(
  parameter int NCH = 16,
  localparam int FW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [FW-1:0] wdata,
  input  logic          enable,
  input  logic [NCH-1:0] ack,
  output logic [FW-1:0] mbox_q,
  output logic [FW-1:0] mask_q,
  output logic [FW-1:0] pend,
  output logic [NCH-1:0] taken
);
  logic [FW-1:0] ack_clr;

  assign pend = enable ? (mbox_q & mask_q) : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_take
    assign taken[c]        = ack[c] && (pend[2*c +: 2] != 2'b00);
    assign ack_clr[2*c +: 2] = {2{taken[c]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mbox_q <= '0;
      mask_q <= '0;
    end else begin
      mbox_q <= (mbox_q & ~ack_clr & ~(clr_we ? wdata : '0))
              | (set_we ? wdata : '0);
      if (mask_we) mask_q <= wdata;
    end
  end
endmodule

// File: rtl/dma_mbox_irq.sv
module dma_mbox_irq #(
  parameter int NCH = 16,
  localparam int FW = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [FW-1:0] wdata,
  input  logic [FW-1:0] evt_bits,
  output logic [FW-1:0] stat_q,
  output logic [FW-1:0] mask_q,
  output logic          irq_o
);
  logic [FW-1:0] stat_n;
  logic [FW-1:0] mask_n;

  always_comb begin
    stat_n = (stat_q & ~(clr_we ? wdata : '0)) | (set_we ? wdata : '0) | evt_bits;
    mask_n = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      stat_q <= stat_n;
      mask_q <= mask_n;
      irq_o  <= |(stat_n & mask_n);
    end
  end
endmodule

// File: rtl/dma_mbox_chans.sv
module dma_mbox_chans
  import dma_mbox_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    wr_sel,
  input  logic [DW-1:0]     wdata,
  input  logic [NCH-1:0]    taken,
  input  logic [2*NCH-1:0]  taken_code,
  input  logic [NCH-1:0]    evt_valid,
  input  logic [2*NCH-1:0]  evt_kind,
  input  logic [3*NCH-1:0]  evt_code,
  output logic [NCH*DW-1:0] words,
  output logic [2*NCH-1:0]  evt_bits
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] w_q;
    evt_kind_e     kind;
    logic          ev;

    assign kind = evt_kind_e'(evt_kind[2*c +: 2]);
    assign ev   = evt_valid[c] && (kind != EV_NONE);

    always_ff @(posedge clk) begin
      if (rst) begin
        w_q <= '0;
      end else if (ev) begin
        case (kind)
          EV_DONE:   w_q[1:0] <= RS_IDLE;
          EV_PAUSED: w_q[1:0] <= RS_PAUSED;
          EV_ERROR: begin
            w_q[1:0]                <= RS_PAUSED;
            w_q[ERR_LSB +: ERR_W]   <= evt_code[ERR_W*c +: ERR_W];
          end
          default: ;
        endcase
      end else if (wr_sel[c]) begin
        w_q <= wdata;
      end else if (taken[c] && taken_code[2*c +: 2] == CMD_START) begin
        w_q[1:0] <= RS_RUN;
      end
    end

    assign evt_bits[2*c +: 2] = !ev ? 2'b00 : (kind == EV_ERROR ? 2'b11 : 2'b01);
    assign words[c*DW +: DW]  = w_q;
  end
endmodule

// File: rtl/dma_mbox_top.sv
module dma_mbox_top
  import dma_mbox_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int AW  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic [2*NCH-1:0] cmd_pend,
  input  logic [NCH-1:0]   cmd_ack,
  input  logic [NCH-1:0]   evt_valid,
  input  logic [2*NCH-1:0] evt_kind,
  input  logic [3*NCH-1:0] evt_code,
  output logic             irq_o
);
  localparam int FW = 2 * NCH;

  logic mb_set_we, mb_clr_we, mb_mask_we;
  logic irq_set_we, irq_clr_we, irq_mask_we, en_we;
  logic en_q;
  logic [FW-1:0] mb_q, mb_mask_q, irq_stat_q, irq_mask_q, evt_bits;
  logic [NCH-1:0] taken, wr_sel;
  logic [NCH*DW-1:0] words;
  logic [DW-1:0] rd_mux;

  assign mb_set_we   = wr_en && addr == AW'(A_MB_SET);
  assign mb_clr_we   = wr_en && addr == AW'(A_MB_CLR);
  assign mb_mask_we  = wr_en && addr == AW'(A_MB_MASK);
  assign irq_set_we  = wr_en && addr == AW'(A_IRQ_SET);
  assign irq_clr_we  = wr_en && addr == AW'(A_IRQ_CLR);
  assign irq_mask_we = wr_en && addr == AW'(A_IRQ_MASK);
  assign en_we       = wr_en && addr == AW'(A_ENABLE);

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign wr_sel[c] = wr_en && addr == AW'(A_CHAN_BASE + c);
  end

  dma_mbox_cmd #(.NCH(NCH)) u_cmd (
    .clk(clk), .rst(rst), .set_we(mb_set_we), .clr_we(mb_clr_we),
    .mask_we(mb_mask_we), .wdata(wdata[FW-1:0]), .enable(en_q),
    .ack(cmd_ack), .mbox_q(mb_q), .mask_q(mb_mask_q), .pend(cmd_pend),
    .taken(taken)
  );

  dma_mbox_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst(rst), .set_we(irq_set_we), .clr_we(irq_clr_we),
    .mask_we(irq_mask_we), .wdata(wdata[FW-1:0]), .evt_bits(evt_bits),
    .stat_q(irq_stat_q), .mask_q(irq_mask_q), .irq_o(irq_o)
  );

  dma_mbox_chans #(.NCH(NCH), .DW(DW)) u_chans (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(wdata), .taken(taken),
    .taken_code(cmd_pend), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_code(evt_code), .words(words), .evt_bits(evt_bits)
  );

  always_ff @(posedge clk) begin
    if (rst)        en_q <= 1'b0;
    else if (en_we) en_q <= wdata[0];
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(A_MB_VAL):   rd_mux[FW-1:0] = mb_q;
      AW'(A_MB_MASK):  rd_mux[FW-1:0] = mb_mask_q;
      AW'(A_IRQ_STAT): rd_mux[FW-1:0] = irq_stat_q;
      AW'(A_IRQ_MASK): rd_mux[FW-1:0] = irq_mask_q;
      AW'(A_ENABLE):   rd_mux[0]      = en_q;
      default: ;
    endcase
    for (int c = 0; c < NCH; c++)
      if (addr == AW'(A_CHAN_BASE + c)) rd_mux = words[c*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_mbox_chk.sv
module dma_mbox_chk
  import dma_mbox_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [2*NCH-1:0] cmd_pend,
  input logic [2*NCH-1:0] mbox_q,
  input logic [2*NCH-1:0] irq_stat,
  input logic [2*NCH-1:0] irq_mask,
  input logic             irq_o,
  input logic             mb_set_we,
  input logic             irq_clr_we,
  input logic [NCH-1:0]   cmd_ack,
  input logic [NCH-1:0]   evt_valid,
  input logic [2*NCH-1:0] evt_kind
);
  AST_PEND_GATED: assert property (@(posedge clk) disable iff (rst)
    !enable |-> cmd_pend == '0); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (irq_stat & irq_mask) == '0 |-> !irq_o); // R8

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (rst)
    !irq_clr_we |=> (irq_stat & $past(irq_stat)) == $past(irq_stat)); // R7

  for (genvar c = 0; c < NCH; c++) begin : g_a
    AST_ERR_BOTH_BITS: assert property (@(posedge clk) disable iff (rst)
      evt_valid[c] && evt_kind[2*c +: 2] == EV_ERROR |=> irq_stat[2*c +: 2] == 2'b11); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      cmd_ack[c] && cmd_pend[2*c +: 2] != 2'b00 && !mb_set_we |=> mbox_q[2*c +: 2] == 2'b00); // R3
  end
endmodule

bind dma_mbox_top dma_mbox_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .enable(en_q), .cmd_pend(cmd_pend), .mbox_q(mb_q),
  .irq_stat(irq_stat_q), .irq_mask(irq_mask_q), .irq_o(irq_o),
  .mb_set_we(mb_set_we), .irq_clr_we(irq_clr_we), .cmd_ack(cmd_ack),
  .evt_valid(evt_valid), .evt_kind(evt_kind)
);

// File: tb/tb_dma_mbox_top.sv
module tb_dma_mbox_top;
  localparam int NCH = 16;
  localparam int DW  = 32;
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [2*NCH-1:0] cmd_pend;
  logic [NCH-1:0] cmd_ack = '0;
  logic [NCH-1:0] evt_valid = '0;
  logic [2*NCH-1:0] evt_kind = '0;
  logic [3*NCH-1:0] evt_code = '0;
  logic irq_o;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  logic [31:0] m_mb, m_mm, m_st, m_im;
  logic        m_en;
  logic [31:0] m_chw [NCH];

  dma_mbox_top #(.NCH(NCH), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmd_pend(cmd_pend), .cmd_ack(cmd_ack),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_code(evt_code),
    .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_rd(input int a);
    if (a == 0) return m_mb;
    if (a == 3) return m_mm;
    if (a == 4) return m_st;
    if (a == 7) return m_im;
    if (a == 8) return {31'b0, m_en};
    if (a >= 32 && a < 32 + NCH) return m_chw[a-32];
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_pend();
    return m_en ? (m_mb & m_mm) : 32'h0;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic void model_wr(input int a, input logic [31:0] d);
    case (a)
      1: m_mb = m_mb | d;
      2: m_mb = m_mb & ~d;
      3: m_mm = d;
      5: m_st = m_st | d;
      6: m_st = m_st & ~d;
      7: m_im = d;
      8: m_en = d[0];
      default: if (a >= 32 && a < 32 + NCH) m_chw[a-32] = d;
    endcase
  endfunction

  function automatic void model_evt(input int ch, input int kind, input logic [2:0] code);
    case (kind)
      0: begin m_st[2*ch] = 1'b1; m_chw[ch][1:0] = 2'b00; end
      1: begin m_st[2*ch] = 1'b1; m_chw[ch][1:0] = 2'b10; end
      2: begin m_st[2*ch +: 2] = 2'b11; m_chw[ch][1:0] = 2'b10; m_chw[ch][4:2] = code; end
      default: ;
    endcase
  endfunction

  function automatic void model_ack(input int ch);
    logic [1:0] f;
    f = exp_pend() >> (2*ch);
    if (f != 2'b00) begin
      m_mb[2*ch +: 2] = 2'b00;
      if (f == 2'b01) m_chw[ch][1:0] = 2'b01;
    end
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    model_wr(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, $sformatf("read addr %0d", a), rdata, exp_rd(a));
  endtask

  task automatic evt(input int ch, input int kind, input logic [2:0] code);
    @(negedge clk);
    evt_valid[ch] = 1'b1; evt_kind[2*ch +: 2] = 2'(kind); evt_code[3*ch +: 3] = code;
    model_evt(ch, kind, code);
    @(negedge clk);
    evt_valid = '0;
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    cmd_ack[ch] = 1'b1;
    model_ack(ch);
    @(negedge clk);
    cmd_ack = '0;
  endtask

  task automatic check_outs(input string tag);
    @(negedge clk);
    chk(tag, "cmd_pend", cmd_pend, exp_pend());
    chk(tag, "irq_o", {31'b0, irq_o}, {31'b0, |(m_st & m_im)});
  endtask

  task automatic check_all();
    rd(0, "R3"); rd(1, "R2"); rd(2, "R2"); rd(3, "R4"); rd(4, "R7");
    rd(5, "R2"); rd(6, "R2"); rd(7, "R8"); rd(8, "R5"); rd(20, "R2");
    for (int c = 0; c < NCH; c++) rd(32 + c, "R9");
    check_outs("R8");
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    m_mb = 0; m_mm = 0; m_st = 0; m_im = 0; m_en = 0;
    for (int c = 0; c < NCH; c++) m_chw[c] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", "rdata after reset", rdata, 32'h0);
    chk("R1", "irq_o after reset", {31'b0, irq_o}, 32'h0);
    check_all();

    // R4: commands held while disabled
    wr(3, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(1, 32'h1 << 4);                 // start on channel 2
    check_outs("R4");
    ack(2);                            // not presented: no effect
    rd(0, "R4");
    wr(8, 32'h1);
    rd(8, "R5");
    check_outs("R4");
    wr(3, 32'hFFFF_FFCF);              // mask channel 2 off
    check_outs("R4");
    wr(3, 32'hFFFF_FFFF);

    // R10: start sequence on channel 1
    wr(32 + 1, (32'h12345 << 5) | 32'h3);
    wr(1, 32'h1 << 2);
    check_outs("R3");
    ack(1);
    rd(33, "R10");
    rd(0, "R3");
    ack(2);                            // start on channel 2 taken now
    rd(34, "R10");

    // R6: pause event, restart, error, idle
    evt(1, 1, 3'd0);
    rd(33, "R6"); rd(4, "R6"); check_outs("R8");
    wr(6, 32'hFFFF_FFFF);
    check_outs("R8");
    wr(32 + 1, (32'h12345 << 5) | 32'h3);
    wr(1, 32'h1 << 2);
    ack(1);
    rd(33, "R10");
    evt(1, 2, 3'd6);
    rd(33, "R6"); rd(4, "R6");
    evt(1, 3, 3'd1);                   // ignored kind
    rd(33, "R6"); rd(4, "R6");
    wr(32 + 1, 32'h0);
    rd(33, "R9");
    evt(2, 0, 3'd0);
    rd(34, "R6");

    // R10: flush acknowledge leaves word alone
    wr(32 + 4, 32'hABC0_0010);
    wr(1, 32'h3 << 8);
    ack(4);
    rd(36, "R10"); rd(0, "R3");

    // R8: mask gating of irq_o
    wr(7, 32'h0);
    check_outs("R8");
    wr(7, 32'h1 << 4);
    check_outs("R8");

    // R7: clear in same cycle as error event on channel 5
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(6); wdata = 32'hFFFF_FFFF;
    evt_valid[5] = 1'b1; evt_kind[11:10] = 2'd2; evt_code[17:15] = 3'd5;
    model_wr(6, 32'hFFFF_FFFF);
    model_evt(5, 2, 3'd5);
    @(negedge clk);
    wr_en = 1'b0; evt_valid = '0;
    rd(4, "R7"); rd(37, "R6");

    // R3: mailbox set in same cycle as acknowledge on channel 3
    wr(32 + 3, (32'h777 << 5) | 32'h3);
    wr(1, 32'h1 << 6);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(1); wdata = 32'h2 << 6;
    cmd_ack[3] = 1'b1;
    model_ack(3);
    model_wr(1, 32'h2 << 6);
    @(negedge clk);
    wr_en = 1'b0; cmd_ack = '0;
    rd(0, "R3"); rd(35, "R10");

    // R2: unmapped address
    rd(60, "R2");

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0: wr(1, $urandom);
        1: wr(2, $urandom);
        2: wr(5, $urandom);
        3: wr(6, $urandom);
        4: evt(int'($urandom % NCH), int'($urandom % 4), 3'($urandom));
        5: ack(int'($urandom % NCH));
        6: wr(32 + int'($urandom % NCH), $urandom);
        default: begin
          int w;
          w = int'($urandom % 3);
          if (w == 0) wr(8, $urandom);
          else if (w == 1) wr(3, $urandom);
          else wr(7, $urandom);
        end
      endcase
      rd(0, "R3"); rd(4, "R7");
      check_outs("R4");
      if (it % 50 == 49) check_all();
    end

    check_all();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule